// File: doc/BRIEF.md
# Switching and Linear Rail Start-Up Supervisor

This block is the digital sequencer for a power controller with one synchronous buck rail and two linear rails. It decides when the rails may start and gates the soft-start ramp. It watches digital flags from the analog window comparators and latches faults. It also drives an open-drain style power-good indication. The DAC, the error amplifier and the comparators sit outside the block; each reaches it as a one-bit flag.

A start needs three conditions: the enable input is high, the supply monitor reports good, and the 5-bit voltage-select code is a valid code. Soft start then counts PWM cycle ticks and raises a duty ceiling in eighths. The linear rails are enabled from the first cycle of soft start. Once soft start ends, the block watches the rails. An over-voltage on the switching rail, or an under-voltage on any rail, latches that section off. Removing any start condition returns the block to the off state and clears every latch. Restoring the conditions starts a new soft start.

Top module: `rail_supervisor`

## Requirements
- R1: A start from the off state happens only when en_i is 1, supply_ok_i is 1 and vsel_i is not 5'b11111. The all-ones code means shutdown and is never valid.
- R2: Soft start advances only on cycles where pwm_tick_i is 1. It lasts SS_CYCLES ticks, then ss_active_o falls and ss_level_o reads STEPS (8 by default).
- R3: While soft start runs, ss_level_o = 1 + floor(count*STEPS/SS_CYCLES), where count is the number of ticks taken so far. Each step is 12.5 % of the duty range. The level is 0 when off.
- R4: In the off state hs_en_o, ls_force_o, ovp_o and lin_en_o are all 0, and pg_low_o is 1.
- R5: In the first cycle of soft start, every lin_en_o bit and hs_en_o are 1.
- R6: pg_low_o is 1 throughout soft start. In the first cycle after soft start it is 0 only if no rail flag was set at the final soft-start edge.
- R7: After soft start, pg_low_o goes to 1 after PG_FILT consecutive clocks with any rail out of range (sw_win_i, sw_uv_i or a lin_uv_i bit). A shorter excursion leaves it at 0. It returns to 0 one clock after the rails are back in range.
- R8: sw_ovp_i after soft start latches over-voltage mode: ovp_o=1, hs_en_o=0, ls_force_o=1, pg_low_o=1, ss_level_o=0. The mode holds after the flag clears. During soft start the flag is ignored.
- R9: After soft start, sw_uv_i latches hs_en_o to 0 and lin_uv_i[k] latches lin_en_o[k] to 0. Either one holds pg_low_o at 1. Both flags are ignored during soft start.
- R10: Dropping en_i, dropping supply_ok_i, or applying code 5'b11111 clears every latch and enters the off state on the next clock. Restoring the conditions re-enters soft start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on reset) |
| en_i | input | 1 | Output enable |
| supply_ok_i | input | 1 | Supply monitor, hysteresis applied outside |
| vsel_i | input | CODE_W | Voltage-select code, all ones = shutdown |
| pwm_tick_i | input | 1 | One pulse per switching cycle |
| sw_ovp_i | input | 1 | Switching rail above 118 % of target |
| sw_win_i | input | 1 | Switching rail outside the ±10 % window |
| sw_uv_i | input | 1 | Switching rail below the under-voltage level |
| lin_uv_i | input | NLIN | Linear rail below the under-voltage level, one bit per rail |
| ss_level_o | output | $clog2(STEPS+1) | Duty ceiling in steps of 1/STEPS |
| ss_active_o | output | 1 | Soft start in progress |
| hs_en_o | output | 1 | Switching gate drive allowed |
| ls_force_o | output | 1 | Low-side drive forced on |
| lin_en_o | output | NLIN | Linear gate drive enable per rail |
| ovp_o | output | 1 | Over-voltage latch, crowbar trigger |
| pg_low_o | output | 1 | Power-good pull-down active |

## Verification
On every cycle the assertions check these properties. Power-good stays masked during soft start. The over-voltage mode keeps the drives parked and does not let go while the start conditions hold. The ramp level never falls within one soft start, and the counter holds on cycles with no tick. Latches do not release on their own, and losing any start condition shuts the outputs. The bench scenarios cover the rest: the exact step schedule of the ramp, the persistence count for every excursion length around the limit, the sweep of all codes against both start inputs, and each of the three clearing paths followed by a restart.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_SOFT = 2'd1,
      ST_RUN  = 2'd2,
      ST_OVP  = 2'd3
   } rsq_state_e;
endpackage

// File: rtl/rsq_ramp.sv
module rsq_ramp #(
   parameter int SS_CYCLES = 4096,
   parameter int STEPS     = 8,
   localparam int CW = $clog2(SS_CYCLES),
   localparam int LW = $clog2(STEPS + 1),
   localparam int SH = CW - $clog2(STEPS)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          run_i,
   input  logic          tick_i,
   output logic          done_o,
   output logic [LW-1:0] level_o
);
   logic [CW-1:0] cnt_q;

   initial begin
      assert ((1 << CW) == SS_CYCLES) else $fatal(1, "SS_CYCLES must be a power of two");
      assert ((1 << $clog2(STEPS)) == STEPS) else $fatal(1, "STEPS must be a power of two");
      assert (STEPS >= 2 && STEPS <= SS_CYCLES) else $fatal(1, "STEPS out of range");
   end

   assign done_o = run_i && tick_i && (cnt_q == CW'(SS_CYCLES - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cnt_q <= '0;
      else if (!run_i)             cnt_q <= '0;
      else if (tick_i && !done_o)  cnt_q <= cnt_q + 1'b1;
   end

   assign level_o = run_i ? (LW'(cnt_q[CW-1:SH]) + LW'(1)) : '0;

   // R3: the ceiling never steps down within one soft start
   a_r3_level_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && $past(run_i)) |-> (level_o >= $past(level_o)));

   // R2: no tick, no progress
   a_r2_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !tick_i) |=> (!run_i || cnt_q == $past(cnt_q)));
endmodule

// File: rtl/rsq_pgfilt.sv
module rsq_pgfilt #(
   parameter int LIMIT = 750,
   localparam int CW = $clog2(LIMIT + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic bad_i,
   output logic hold_o
);
   logic [CW-1:0] cnt_q;

   initial begin
      assert (LIMIT >= 1) else $fatal(1, "LIMIT must be at least one");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cnt_q <= CW'(LIMIT);
      else if (!arm_i)              cnt_q <= bad_i ? CW'(LIMIT) : '0;
      else if (!bad_i)              cnt_q <= '0;
      else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
   end

   assign hold_o = (cnt_q == CW'(LIMIT));

   // R7: a clean sample while monitoring clears the persistence count
   a_r7_clear_on_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arm_i && !bad_i) |=> (cnt_q == '0));

   // R7: the hold only rises after a bad sample
   a_r7_rise_needs_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hold_o) |-> $past(bad_i));
endmodule

// File: rtl/rsq_uvlatch.sv
module rsq_uvlatch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic arm_i,
   input  logic trip_i,
   output logic lat_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              lat_o <= 1'b0;
      else if (clr_i)           lat_o <= 1'b0;
      else if (arm_i && trip_i) lat_o <= 1'b1;
   end

   // R9: a latched section stays off until a clear
   a_r9_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lat_o && !clr_i) |=> lat_o);
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor #(
   parameter int CODE_W    = 5,
   parameter int NLIN      = 2,
   parameter int SS_CYCLES = 4096,
   parameter int STEPS     = 8,
   parameter int PG_FILT   = 750,
   localparam int LW = $clog2(STEPS + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              supply_ok_i,
   input  logic [CODE_W-1:0] vsel_i,
   input  logic              pwm_tick_i,
   input  logic              sw_ovp_i,
   input  logic              sw_win_i,
   input  logic              sw_uv_i,
   input  logic [NLIN-1:0]   lin_uv_i,
   output logic [LW-1:0]     ss_level_o,
   output logic              ss_active_o,
   output logic              hs_en_o,
   output logic              ls_force_o,
   output logic [NLIN-1:0]   lin_en_o,
   output logic              ovp_o,
   output logic              pg_low_o
);
   import rsq_pkg::*;

   rsq_state_e    state_q, state_d;
   logic          start_ok, ss_done, post_ss, any_bad, pg_hold, sw_lat;
   logic [LW-1:0] ramp_lvl;
   logic [NLIN-1:0] lin_lat;

   initial begin
      assert (CODE_W >= 1) else $fatal(1, "CODE_W must be positive");
      assert (NLIN >= 1) else $fatal(1, "NLIN must be positive");
   end

   assign start_ok = en_i && supply_ok_i && (vsel_i != '1);
   assign post_ss  = (state_q == ST_RUN) || (state_q == ST_OVP);
   assign any_bad  = sw_win_i || sw_uv_i || (|lin_uv_i);

   always_comb begin
      state_d = state_q;
      if (!start_ok) state_d = ST_OFF;
      else begin
         case (state_q)
            ST_OFF:  state_d = ST_SOFT;
            ST_SOFT: if (ss_done)  state_d = ST_RUN;
            ST_RUN:  if (sw_ovp_i) state_d = ST_OVP;
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_OFF;
      else         state_q <= state_d;
   end

   rsq_ramp #(.SS_CYCLES(SS_CYCLES), .STEPS(STEPS)) ramp_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state_q == ST_SOFT),
      .tick_i(pwm_tick_i), .done_o(ss_done), .level_o(ramp_lvl));

   rsq_pgfilt #(.LIMIT(PG_FILT)) pgf_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(state_q == ST_RUN),
      .bad_i(any_bad), .hold_o(pg_hold));

   rsq_uvlatch sw_uv_i_lat (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!start_ok), .arm_i(post_ss),
      .trip_i(sw_uv_i), .lat_o(sw_lat));

   for (genvar k = 0; k < NLIN; k++) begin : g_lin
      rsq_uvlatch lat_i (
         .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!start_ok), .arm_i(post_ss),
         .trip_i(lin_uv_i[k]), .lat_o(lin_lat[k]));
      assign lin_en_o[k] = (state_q != ST_OFF) && !lin_lat[k];
   end

   assign ss_active_o = (state_q == ST_SOFT);
   assign ss_level_o  = (state_q == ST_SOFT) ? ramp_lvl :
                        (state_q == ST_RUN)  ? LW'(STEPS) : '0;
   assign hs_en_o     = ((state_q == ST_SOFT) || (state_q == ST_RUN)) && !sw_lat;
   assign ls_force_o  = (state_q == ST_OVP);
   assign ovp_o       = (state_q == ST_OVP);
   assign pg_low_o    = !((state_q == ST_RUN) && !sw_lat && !(|lin_lat) && !pg_hold);

   // R10/R4: losing a start condition shuts every drive on the next clock
   a_r10_drop_shuts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_ok |=> (!hs_en_o && !ls_force_o && !ovp_o && lin_en_o == '0 && pg_low_o));

   // R6: power-good masked during soft start
   a_r6_pg_masked_soft: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ss_active_o |-> pg_low_o);

   // R8: over-voltage parks the drives
   a_r8_ovp_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovp_o |-> (!hs_en_o && ls_force_o && pg_low_o && ss_level_o == '0));

   // R8: over-voltage is sticky while start conditions hold
   a_r8_ovp_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovp_o && start_ok) |=> ovp_o);

   // R1: a rise of soft start needs all three start conditions
   a_r1_start_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ss_active_o) |-> $past(start_ok));
endmodule

// File: tb/rail_supervisor_tb_top.sv
module rail_supervisor_tb_top;
   localparam int SS = 64;
   localparam int ST = 8;
   localparam int PF = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, sup = 1'b0, tick = 1'b0;
   logic [4:0] vsel = 5'd5;
   logic       ovp_in = 1'b0, win_in = 1'b0, uv_in = 1'b0;
   logic [1:0] luv = 2'b00;
   logic [3:0] lvl;
   logic       ssa, hs, ls, ovp, pgl;
   logic [1:0] len;

   int n_run = 0, n_fail = 0, cyc = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rail_supervisor #(.CODE_W(5), .NLIN(2), .SS_CYCLES(SS), .STEPS(ST), .PG_FILT(PF)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .supply_ok_i(sup), .vsel_i(vsel),
      .pwm_tick_i(tick), .sw_ovp_i(ovp_in), .sw_win_i(win_in), .sw_uv_i(uv_in),
      .lin_uv_i(luv), .ss_level_o(lvl), .ss_active_o(ssa), .hs_en_o(hs),
      .ls_force_o(ls), .lin_en_o(len), .ovp_o(ovp), .pg_low_o(pgl));

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // from any state: off, then a full soft start; sw_win driven to bad_end at final edge
   task automatic go_run(input logic bad_end);
      en = 1'b0; step();
      en = 1'b1; sup = 1'b1; vsel = 5'd5; tick = 1'b1;
      ovp_in = 1'b0; win_in = 1'b0; uv_in = 1'b0; luv = 2'b00;
      step();
      repeat (SS - 1) step();
      win_in = bad_end;
      step();
   endtask

   initial begin
      repeat (3) step();
      // R4 reset state
      chk("R4 reset hs_en", hs, 0);
      chk("R4 reset lin_en", len, 0);
      chk("R4 reset pg_low", pgl, 1);
      chk("R3 reset level", lvl, 0);
      rst_n = 1'b1; step();
      chk("R4 off ovp", ovp, 0);
      chk("R4 off ls_force", ls, 0);

      // R1 sweep of codes against enable and supply
      for (int e = 0; e < 2; e++)
         for (int s = 0; s < 2; s++)
            for (int c = 0; c < 32; c++) begin
               en = e[0]; sup = s[0]; vsel = c[4:0]; step();
               chk("R1 start gate", ssa, (e == 1 && s == 1 && c != 31) ? 1 : 0);
               en = 1'b0; step();
               chk("R4 off after sweep", hs, 0);
            end

      // R2/R3/R5/R6 full soft start with a tick every cycle
      en = 1'b1; sup = 1'b1; vsel = 5'd5; tick = 1'b1; step();
      chk("R5 lin_en first cycle", len, 3);
      chk("R5 hs_en first cycle", hs, 1);
      chk("R6 pg masked soft", pgl, 1);
      chk("R3 level at 0", lvl, 1);
      for (int k = 1; k < SS; k++) begin
         step();
         chk("R3 level step", lvl, k * ST / SS + 1);
         chk("R2 still soft", ssa, 1);
         chk("R6 pg masked", pgl, 1);
      end
      step();
      chk("R2 soft ends", ssa, 0);
      chk("R2 level released", lvl, ST);
      chk("R6 pg good at end", pgl, 0);

      // R2 ticks gate progress
      en = 1'b0; step(); en = 1'b1; tick = 1'b0; step();
      repeat (20) step();
      chk("R2 no tick no progress", lvl, 1);
      chk("R2 no tick still soft", ssa, 1);
      for (int k = 0; k < SS; k++) begin
         tick = 1'b1; step();
         tick = 1'b0; step();
      end
      chk("R2 done after SS ticks", ssa, 0);

      // R6 rail bad at end of soft start
      go_run(1'b1);
      chk("R6 pg held low when bad at end", pgl, 1);
      win_in = 1'b0; step();
      chk("R7 pg recovers", pgl, 0);

      // R7 persistence sweep
      for (int L = 1; L <= PF + 2; L++) begin
         win_in = 1'b1;
         for (int i = 1; i <= L; i++) begin
            step();
            chk("R7 persistence", pgl, (i >= PF) ? 1 : 0);
         end
         win_in = 1'b0; step();
         chk("R7 back in range", pgl, 0);
      end

      // R8 ignored during soft start
      en = 1'b0; step(); en = 1'b1; step();
      ovp_in = 1'b1; uv_in = 1'b1; luv = 2'b11; step();
      chk("R8 ovp ignored in soft", ovp, 0);
      chk("R9 uv ignored in soft hs", hs, 1);
      chk("R9 uv ignored in soft lin", len, 3);

      // R8 latch and the three clearing paths (R10)
      for (int m = 0; m < 3; m++) begin
         go_run(1'b0);
         ovp_in = 1'b1; step();
         chk("R8 ovp set", ovp, 1);
         chk("R8 hs low", hs, 0);
         chk("R8 ls high", ls, 1);
         chk("R8 pg low", pgl, 1);
         chk("R8 level zero", lvl, 0);
         ovp_in = 1'b0; repeat (3) step();
         chk("R8 ovp sticky", ovp, 1);
         if (m == 0) en = 1'b0;
         else if (m == 1) sup = 1'b0;
         else vsel = 5'b11111;
         step();
         chk("R10 cleared ovp", ovp, 0);
         chk("R10 cleared ls", ls, 0);
         en = 1'b1; sup = 1'b1; vsel = 5'd9; step();
         chk("R10 restart soft", ssa, 1);
      end

      // R9 switching under-voltage
      go_run(1'b0);
      uv_in = 1'b1; step();
      chk("R9 sw uv hs off", hs, 0);
      chk("R9 sw uv lin kept", len, 3);
      chk("R9 sw uv pg low", pgl, 1);
      uv_in = 1'b0; repeat (3) step();
      chk("R9 sw uv sticky", hs, 0);
      chk("R9 sw uv pg sticky", pgl, 1);

      // R9 linear under-voltage on rail 1
      go_run(1'b0);
      luv = 2'b10; step();
      luv = 2'b00; repeat (2) step();
      chk("R9 lin uv rail1", len, 1);
      chk("R9 lin uv hs kept", hs, 1);
      chk("R9 lin uv pg low", pgl, 1);
      vsel = 5'b11111; step();
      chk("R10 float clears", len, 0);
      vsel = 5'd3; step();
      chk("R10 lin restart", len, 3);

      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      wait (cyc >= 100000);
      if (!finished) begin
         finished = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule